// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer that sits inside a per-processor local interrupt controller. Software programs it through a small register port. It can write a starting count and a clock divide setting, read the live count, and set a timer entry that holds a vector, a mask bit and a periodic/one-shot bit. The counter steps once for every 2^shift input clocks, where a power-of-two prescaler derives shift from the divide setting.

When the count runs out, the block emits a one-cycle interrupt request carrying the entry's 8-bit vector, unless the entry is masked. In periodic mode the counter reloads and one period lasts the starting count plus one prescaled ticks. In one-shot mode the counter parks at zero after firing once. A starting count of zero leaves the timer idle in either mode.

The same register port also holds three reset-defined companion registers: task priority, spurious vector and destination format. These let the surrounding controller take its documented reset state from one place.

Top module: `lic_timer`

## Requirements
- R1: After reset, reads return the following values. Starting count 0, live count 0, divide setting 0, timer entry 0x0001_0000 (masked, one-shot, vector 0), task priority 0, spurious vector 0xFF, destination format 0xF. The interrupt output is low.
- R2: The select codes are 0 starting count (read/write), 1 live count (read only), 2 divide setting (4 bits), 3 timer entry (bits 17, 16 and 7:0 kept), 4 task priority (8 bits), 5 spurious vector (8 bits) and 6 destination format (4 bits). Bits outside these fields read as 0. A write to code 1 or code 7 changes nothing, and code 7 reads as 0.
- R3: The divide setting selects shift from bits {3,1,0}. Values 000 to 110 give shift 1 to 7 (divide by 2 up to 128), and value 111 gives shift 0 (divide by 1). The live count first drops 2^shift clock edges after the edge that takes a starting-count write.
- R4: In periodic mode (entry bit 17 set) with starting count N>0, the live count steps N, N-1, ..., 0 and then reloads N. The first pulse appears (N+1)*2^shift edges after the write, and further pulses follow every (N+1)*2^shift edges.
- R5: In periodic mode a starting count of 0 never produces a pulse, and the live count stays 0.
- R6: In one-shot mode (entry bit 17 clear) the count falls from N to 0 and stays at 0. Exactly one pulse appears, (N+1)*2^shift edges after the write.
- R7: Writing a starting count of 0 stops a running timer at once. The live count reads 0 from the next cycle, and no pulse follows.
- R8: While entry bit 16 (mask) is set, no pulse is raised, but the count keeps running. Clearing the mask lets later expiries fire on the original schedule.
- R9: Each pulse lasts exactly one cycle, and the vector output then equals entry bits 7:0.
- R10: Only a starting-count write reloads the counter and restarts the prescaler. A rewrite of the starting count while the timer runs restarts the period from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| irq_o | output | 1 | One-cycle expiry interrupt request |
| irq_vec_o | output | 8 | Vector that goes with irq_o |

## Verification
The assertions assume that the starting count changes only through a write on select code 0. They also assume the timer entry is stable within a cycle, so that a pulse can be compared with the entry and mask values of the cycle before it. The bench keeps to this: it drives every register write at the falling edge and holds it for exactly one rising edge. It changes the mask or mode only through a full entry write. It also keeps each periodic test at a count of at least 1, so pulses can never come back to back.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;

  localparam int unsigned VEC_W      = 8;
  localparam int unsigned DIV_W      = 4;
  localparam int unsigned SHIFT_W    = 3;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned MASK_BIT   = 16;
  localparam int unsigned MODE_BIT   = 17;
  localparam int unsigned PRIO_W     = 8;
  localparam int unsigned SPUR_W     = 8;
  localparam int unsigned DFMT_W     = 4;

  localparam logic [SPUR_W-1:0] SPUR_RESET = '1;
  localparam logic [DFMT_W-1:0] DFMT_RESET = '1;

  typedef enum logic [SEL_W-1:0] {
    SEL_INIT  = 3'd0,
    SEL_CUR   = 3'd1,
    SEL_DIV   = 3'd2,
    SEL_ENTRY = 3'd3,
    SEL_PRIO  = 3'd4,
    SEL_SPUR  = 3'd5,
    SEL_DFMT  = 3'd6,
    SEL_NONE  = 3'd7
  } sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  localparam entry_t ENTRY_RESET = '{periodic: 1'b0, masked: 1'b1, vector: '0};

  // divide setting bits {3,1,0}: 0..6 -> shift 1..7, 7 -> shift 0
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [SHIFT_W-1:0] code;
    code = {d[3], d[1:0]};
    if (code == 3'd7) return '0;
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/lic_prescaler.sv
module lic_prescaler #(
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  localparam int unsigned PW = (1 << SHIFT_W) - 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] pcnt_d;
  logic [PW-1:0] low_mask;

  // low_mask has shift ones at the bottom
  always_comb begin
    low_mask = ~({PW{1'b1}} << shift);
    tick     = ((pcnt_q & low_mask) == low_mask);
  end

  always_comb begin
    if (restart) pcnt_d = '0;
    else         pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/lic_countdown.sv
module lic_countdown #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign count    = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
      run_d = |load_val;
    end else if (tick && run_q) begin
      if (cnt_zero) begin
        expire = 1'b1;
        if (periodic) cnt_d = reload_val;
        else          run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [DATA_W-1:0]  cur_count,
  output logic [DATA_W-1:0]  rd_data,
  output logic [DATA_W-1:0]  init_count,
  output logic               init_load,
  output logic [SHIFT_W-1:0] shift,
  output entry_t             entry
);

  logic [DATA_W-1:0] init_q, init_d;
  logic [DIV_W-1:0]  div_q, div_d;
  entry_t            entry_q, entry_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [SPUR_W-1:0] spur_q, spur_d;
  logic [DFMT_W-1:0] dfmt_q, dfmt_d;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^{wr_data[DATA_W-1:MODE_BIT+1], wr_data[MASK_BIT-1:VEC_W]};

  // next-state
  always_comb begin
    init_d    = init_q;
    div_d     = div_q;
    entry_d   = entry_q;
    prio_d    = prio_q;
    spur_d    = spur_q;
    dfmt_d    = dfmt_q;
    init_load = 1'b0;
    if (wr_en) begin
      unique case (sel_e'(wr_sel))
        SEL_INIT: begin
          init_d    = wr_data;
          init_load = 1'b1;
        end
        SEL_DIV:   div_d = wr_data[DIV_W-1:0];
        SEL_ENTRY: entry_d = '{periodic: wr_data[MODE_BIT],
                               masked:   wr_data[MASK_BIT],
                               vector:   wr_data[VEC_W-1:0]};
        SEL_PRIO:  prio_d = wr_data[PRIO_W-1:0];
        SEL_SPUR:  spur_d = wr_data[SPUR_W-1:0];
        SEL_DFMT:  dfmt_d = wr_data[DFMT_W-1:0];
        default: ;
      endcase
    end
  end

  // registers with an explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      div_q   <= '0;
      entry_q <= ENTRY_RESET;
      prio_q  <= '0;
      spur_q  <= SPUR_RESET;
      dfmt_q  <= DFMT_RESET;
    end else if (wr_en) begin
      init_q  <= init_d;
      div_q   <= div_d;
      entry_q <= entry_d;
      prio_q  <= prio_d;
      spur_q  <= spur_d;
      dfmt_q  <= dfmt_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (sel_e'(rd_sel))
      SEL_INIT:  rd_data = init_q;
      SEL_CUR:   rd_data = cur_count;
      SEL_DIV:   rd_data[DIV_W-1:0] = div_q;
      SEL_ENTRY: begin
        rd_data[MODE_BIT]    = entry_q.periodic;
        rd_data[MASK_BIT]    = entry_q.masked;
        rd_data[VEC_W-1:0]   = entry_q.vector;
      end
      SEL_PRIO:  rd_data[PRIO_W-1:0] = prio_q;
      SEL_SPUR:  rd_data[SPUR_W-1:0] = spur_q;
      SEL_DFMT:  rd_data[DFMT_W-1:0] = dfmt_q;
      default:   rd_data = '0;
    endcase
  end

  assign init_count = init_q;
  assign shift      = div_to_shift(div_q);
  assign entry      = entry_q;

endmodule

// File: rtl/lic_timer.sv
module lic_timer
  import lic_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o
);

  localparam int unsigned CNT_W = DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [CNT_W-1:0]   init_count;
  logic [CNT_W-1:0]   cur_count;
  logic               wr_init;
  logic [SHIFT_W-1:0] shift;
  entry_t             entry;
  logic               tick;
  logic               expire;
  logic               lvt_periodic;
  logic               lvt_mask;
  logic [VEC_W-1:0]   lvt_vec;

  lic_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_q),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .cur_count  (cur_count),
    .rd_data    (rd_data),
    .init_count (init_count),
    .init_load  (wr_init),
    .shift      (shift),
    .entry      (entry)
  );

  assign lvt_periodic = entry.periodic;
  assign lvt_mask     = entry.masked;
  assign lvt_vec      = entry.vector;

  lic_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_q),
    .restart (wr_init),
    .shift   (shift),
    .tick    (tick)
  );

  lic_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q),
    .load       (wr_init),
    .load_val   (wr_data),
    .reload_val (init_count),
    .tick       (tick),
    .periodic   (lvt_periodic),
    .count      (cur_count),
    .expire     (expire)
  );

  // interrupt pulse stage
  logic             irq_d, irq_q;
  logic [VEC_W-1:0] vec_d, vec_q;

  always_comb begin
    irq_d = expire && !lvt_mask;
    vec_d = irq_d ? lvt_vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

endmodule

// File: rtl/lic_timer_chk.sv
module lic_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_q,
  input logic             wr_init,
  input logic [CNT_W-1:0] init_count,
  input logic [CNT_W-1:0] cur_count,
  input logic             lvt_periodic,
  input logic             lvt_mask,
  input logic [7:0]       lvt_vec,
  input logic             irq_o,
  input logic [7:0]       irq_vec_o
);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |=> !irq_o);

  // R9
  pulse_vector_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> (irq_vec_o == $past(lvt_vec)));

  // R8
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> !$past(lvt_mask));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cur_count <= init_count);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_init |=> (cur_count == $past(cur_count)) ||
                 (cur_count == $past(cur_count) - 1'b1) ||
                 ($past(cur_count) == '0 && cur_count == init_count));

  // R5
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (init_count == '0) |=> !irq_o);

  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!lvt_periodic && cur_count == '0 && !wr_init) |=> (cur_count == '0));

endmodule

bind lic_timer lic_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .wr_init      (wr_init),
  .init_count   (init_count),
  .cur_count    (cur_count),
  .lvt_periodic (lvt_periodic),
  .lvt_mask     (lvt_mask),
  .lvt_vec      (lvt_vec),
  .irq_o        (irq_o),
  .irq_vec_o    (irq_vec_o)
);

// File: tb/lic_timer_test.sv
`timescale 1ns/1ps
module lic_timer_test;

  localparam int HALF = 10;               // 50 MHz
  localparam int WATCHDOG_CYC = 150000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic        irq_o;
  logic [7:0]  irq_vec_o;

  int cyc;
  int npulse;
  int checks;
  int fails;
  bit done;

  lic_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial npulse = 0;
  always @(negedge clk) if (rst_n && irq_o === 1'b1) npulse++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d, output int stamp);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    stamp = cyc;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  // wait for the falling edge after rising edge number base+k
  task automatic to_k(input int base, input int k);
    while (cyc < base + k) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 start count", v, 32'h0);
    rd(3'd1, v); chk("R1 live count", v, 32'h0);
    rd(3'd2, v); chk("R1 divide", v, 32'h0);
    rd(3'd3, v); chk("R1 entry", v, 32'h0001_0000);
    rd(3'd4, v); chk("R1 priority", v, 32'h0);
    rd(3'd5, v); chk("R1 spurious", v, 32'hFF);
    rd(3'd6, v); chk("R1 dest format", v, 32'hF);
    chk("R1 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    int s;
    wr(3'd2, 32'hFFFF_FFFF, s); rd(3'd2, v); chk("R2 divide width", v, 32'hF);
    wr(3'd3, 32'hFFFF_FFFF, s); rd(3'd3, v); chk("R2 entry fields", v, 32'h0003_00FF);
    wr(3'd4, 32'hFFFF_FFFF, s); rd(3'd4, v); chk("R2 priority width", v, 32'hFF);
    wr(3'd5, 32'h1234_5678, s); rd(3'd5, v); chk("R2 spurious width", v, 32'h78);
    wr(3'd6, 32'hABCD_EF01, s); rd(3'd6, v); chk("R2 dest format width", v, 32'h1);
    wr(3'd3, 32'h0001_0000, s);
    wr(3'd0, 32'h0, s);
    wr(3'd1, 32'h55, s); rd(3'd1, v); chk("R2 live count ignores write", v, 32'h0);
    wr(3'd7, 32'h77, s); rd(3'd7, v); chk("R2 code 7 reads 0", v, 32'h0);
    rd(3'd0, v); chk("R2 code 7 write ignored", v, 32'h0);
    wr(3'd2, 32'hB, s);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    int s;
    wr(3'd2, 32'hB, s);
    wr(3'd3, 32'h0002_0042, s);
    wr(3'd0, 32'd5, s);
    rd(3'd1, v); chk("R10 load value", v, 32'd5);
    to_k(s, 1); rd(3'd1, v); chk("R4 first step", v, 32'd4);
    to_k(s, 5); rd(3'd1, v); chk("R4 reaches zero", v, 32'd0);
    chk("R4 no pulse before period", {31'b0, irq_o}, 32'h0);
    to_k(s, 6); chk("R4 first pulse", {31'b0, irq_o}, 32'h1);
    chk("R9 vector", {24'b0, irq_vec_o}, 32'h42);
    rd(3'd1, v); chk("R4 reload", v, 32'd5);
    to_k(s, 7); chk("R9 one cycle", {31'b0, irq_o}, 32'h0);
    to_k(s, 12); chk("R4 second pulse", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h0, s);
  endtask

  task automatic t_divide();
    logic [31:0] v;
    int s;
    wr(3'd3, 32'h0002_0042, s);
    wr(3'd2, 32'h1, s);                       // divide by 4
    wr(3'd0, 32'd3, s);
    to_k(s, 3); rd(3'd1, v); chk("R3 held before tick", v, 32'd3);
    to_k(s, 4); rd(3'd1, v); chk("R3 first tick at 4", v, 32'd2);
    to_k(s, 15); chk("R3 no early pulse /4", {31'b0, irq_o}, 32'h0);
    to_k(s, 16); chk("R3 pulse at 16", {31'b0, irq_o}, 32'h1);
    wr(3'd2, 32'h0, s);                       // divide by 2
    wr(3'd0, 32'd2, s);
    to_k(s, 5); chk("R3 no early pulse /2", {31'b0, irq_o}, 32'h0);
    to_k(s, 6); chk("R3 pulse at 6", {31'b0, irq_o}, 32'h1);
    wr(3'd2, 32'hA, s);                       // divide by 128
    wr(3'd0, 32'd1, s);
    to_k(s, 255); chk("R3 no early pulse /128", {31'b0, irq_o}, 32'h0);
    to_k(s, 256); chk("R3 pulse at 256", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h0, s);
    wr(3'd2, 32'hB, s);
  endtask

  task automatic t_periodic_zero();
    logic [31:0] v;
    int s, p0;
    wr(3'd3, 32'h0002_0042, s);
    wr(3'd0, 32'h0, s);
    p0 = npulse;
    to_k(s, 50);
    chk("R5 no pulse", npulse - p0, 0);
    rd(3'd1, v); chk("R5 count stays 0", v, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int s, p0;
    wr(3'd3, 32'h0000_0033, s);
    p0 = npulse;
    wr(3'd0, 32'd4, s);
    to_k(s, 4); rd(3'd1, v); chk("R6 reaches zero", v, 32'd0);
    chk("R6 no pulse yet", {31'b0, irq_o}, 32'h0);
    to_k(s, 5); chk("R6 pulse", {31'b0, irq_o}, 32'h1);
    chk("R9 one-shot vector", {24'b0, irq_vec_o}, 32'h33);
    to_k(s, 40);
    chk("R6 single pulse", npulse - p0, 1);
    rd(3'd1, v); chk("R6 holds zero", v, 32'd0);
  endtask

  task automatic t_oneshot_stop();
    logic [31:0] v;
    int s, s2, p0;
    wr(3'd3, 32'h0000_0033, s);
    wr(3'd0, 32'd100, s);
    to_k(s, 3); rd(3'd1, v); chk("R7 running", v, 32'd97);
    p0 = npulse;
    wr(3'd0, 32'd0, s2);
    rd(3'd1, v); chk("R7 reads zero", v, 32'd0);
    to_k(s2, 120);
    chk("R7 no pulse after stop", npulse - p0, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    int s, s2, p0;
    wr(3'd3, 32'h0003_0011, s);
    p0 = npulse;
    wr(3'd0, 32'd3, s);
    to_k(s, 2); rd(3'd1, v); chk("R8 counting while masked", v, 32'd1);
    to_k(s, 12);
    chk("R8 masked no pulse", npulse - p0, 0);
    wr(3'd3, 32'h0002_0011, s2);             // unmask, no restart
    to_k(s, 14); rd(3'd1, v); chk("R10 mask change keeps phase", v, 32'd1);
    to_k(s, 15); chk("R8 no off-schedule pulse", {31'b0, irq_o}, 32'h0);
    to_k(s, 16); chk("R8 pulse after unmask", {31'b0, irq_o}, 32'h1);
    chk("R9 unmasked vector", {24'b0, irq_vec_o}, 32'h11);
    wr(3'd0, 32'h0, s);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    int s, s2;
    wr(3'd3, 32'h0002_0042, s);
    wr(3'd0, 32'd9, s);
    to_k(s, 4); rd(3'd1, v); chk("R10 before rewrite", v, 32'd5);
    wr(3'd0, 32'd7, s2);
    rd(3'd1, v); chk("R10 rewrite reloads", v, 32'd7);
    to_k(s2, 7); chk("R10 no early pulse", {31'b0, irq_o}, 32'h0);
    to_k(s2, 8); chk("R10 pulse from rewrite", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h0, s);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_periodic();
    t_divide();
    t_periodic_zero();
    t_oneshot();
    t_oneshot_stop();
    t_mask();
    t_reload();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(2 * HALF * WATCHDOG_CYC);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected end before %0d", cyc, WATCHDOG_CYC);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule